// File: doc/BRIEF.md
# Paged MDIO Register Bridge

This block sits on the slave side of a management bus. It turns 16-bit management-register reads and writes into 32-bit reads and writes on an internal register bus. The serial management front end is modelled as a parallel request port. Each request carries a PHY address, a register number, a direction and, for writes, 16 bits of data. One response comes back on the next clock.

The internal bus takes word addresses of `PAGE_W + 7` bits. The upper `PAGE_W` bits come from a page register. Software loads it by writing register 0x10 of PHY address 0x1F. The lower seven bits come from the access itself. The PHY address, which must lie in 0x10..0x17, supplies word-address bits [6:4]. Register-number bits [4:1] supply word-address bits [3:0]. Register-number bit 0 picks the half of the word: 0 is the low half and 1 is the high half.

Software writes a word high half first, then low half. The high half is staged. The low half then commits all 32 bits in one bus cycle. Software reads a word low half first. That read fetches the whole word and keeps its upper 16 bits for the high-half read that follows.

Top module: `mdio_page_bridge`

## Requirements
- R1: After synchronous active-low reset, `resp_valid` is 0, `resp_data` is 0x0000 and the page register is 0.
- R2: A write to PHY 0x1F, register 0x10 loads the page register from `req_wdata[PAGE_W-1:0]`. A read of that location returns the page zero-extended to 16 bits. Neither access strobes the internal bus.
- R3: A data access (PHY address 0x10..0x17) targets word address {page, req_phy[2:0], req_reg[4:1]}.
- R4: A write to an odd register number in the data window stages `req_wdata` as the upper half and issues no bus write.
- R5: A write to an even register number in the data window raises `bus_wr_en` for that one request cycle, with `bus_wdata` = {staged upper half, req_wdata}.
- R6: A read of an even register number in the data window raises `bus_rd_en` in the request cycle. It returns `bus_rdata[15:0]` and latches `bus_rdata[31:16]`.
- R7: A read of an odd register number in the data window returns the latched upper half and issues no bus read.
- R8: A request to PHY 0x00..0x0F, or to PHY 0x18..0x1F other than the page location, is ignored. It causes no bus strobe, changes neither the page, the staged half nor the latched half, and reads back 0xFFFF.
- R9: Every request cycle is answered by `resp_valid` high on the following cycle, with `resp_data` updated at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address of the request |
| req_reg | input | 5 | Register number of the request |
| req_wdata | input | 16 | Write data |
| resp_valid | output | 1 | Response valid, one cycle after the request |
| resp_data | output | 16 | Read data (unchanged content is irrelevant for writes) |
| bus_wr_en | output | 1 | Internal bus write strobe |
| bus_rd_en | output | 1 | Internal bus read strobe |
| bus_addr | output | PAGE_W+7 | Internal word address |
| bus_wdata | output | 32 | Internal write data |
| bus_rdata | input | 32 | Internal read data, valid in the same cycle as `bus_rd_en` |

## Verification
The assertions assume two things about the inputs. `req_valid` requests last exactly one cycle each. The internal slave answers a read combinationally, in the same cycle as `bus_rd_en`. The stimulus drives every request on the falling edge and holds it for one clock. The bench slave returns an arithmetic function of `bus_addr` with no wait state. The sweeps always send a high-then-low write pair and a low-then-high read pair. Ignored requests are wedged between the two halves of a pair so that the staged and latched halves are exposed to them.

// File: rtl/mdio_pgbr_pkg.sv
// Package: shared access classification for the paged MDIO bridge.
// Assumes nothing beyond being compiled before the modules that import it.
package mdio_pgbr_pkg;

    // Kind of a decoded management request
    typedef enum logic [2:0] {
        ACC_IGNORE  = 3'd0,
        ACC_PAGE_WR = 3'd1,
        ACC_PAGE_RD = 3'd2,
        ACC_WR_HI   = 3'd3,
        ACC_WR_LO   = 3'd4,
        ACC_RD_LO   = 3'd5,
        ACC_RD_HI   = 3'd6
    } acc_kind_e;

    localparam logic [4:0] PAGE_PHY     = 5'h1F;
    localparam logic [4:0] PAGE_REG     = 5'h10;
    localparam logic [1:0] DATA_WIN_TOP = 2'b10;  // PHY[4:3] of 0x10..0x17

endpackage

// File: rtl/mdio_pgbr_decode.sv
// Module: mdio_pgbr_decode
// Classifies one management request and forms the internal word address.
// Assumes the request fields are stable while req_valid is high; purely
// combinational, so the kind is valid in the same cycle as the request.
module mdio_pgbr_decode
    import mdio_pgbr_pkg::*;
#(
    parameter int PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + 7
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [4:0]        req_phy,
    input  logic [4:0]        req_reg,
    input  logic [PAGE_W-1:0] page,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] word_addr
);

    logic in_window;
    logic is_page;

    // Window and page-location match
    always_comb begin
        in_window = (req_phy[4:3] == DATA_WIN_TOP);
        is_page   = (req_phy == PAGE_PHY) && (req_reg == PAGE_REG);
    end

    // Request classification by window, direction and half
    always_comb begin
        kind = ACC_IGNORE;
        if (req_valid) begin
            if (is_page)
                kind = req_write ? ACC_PAGE_WR : ACC_PAGE_RD;
            else if (in_window) begin
                if (req_write)
                    kind = req_reg[0] ? ACC_WR_HI : ACC_WR_LO;
                else
                    kind = req_reg[0] ? ACC_RD_HI : ACC_RD_LO;
            end
        end
    end

    // Word address: page on top, PHY low bits, register number without half bit
    always_comb begin
        word_addr = {page, req_phy[2:0], req_reg[4:1]};
    end

endmodule

// File: rtl/mdio_pgbr_halves.sv
// Module: mdio_pgbr_halves
// Holds the staged upper half of a pending write and the latched upper half
// of the last low-half read. Assumes the internal slave answers a read in
// the same cycle the read strobe is raised.
module mdio_pgbr_halves
    import mdio_pgbr_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_kind_e           kind,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] bus_rdata,
    output logic [HALF_W-1:0]   stage_q,
    output logic [HALF_W-1:0]   upper_q
);

    // Capture the high half of a write ahead of its low half
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (kind == ACC_WR_HI)
            stage_q <= wdata;
    end

    // Keep the upper half fetched by a low-half read
    always_ff @(posedge clk) begin
        if (!rst_n)
            upper_q <= '0;
        else if (kind == ACC_RD_LO)
            upper_q <= bus_rdata[2*HALF_W-1:HALF_W];
    end

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_WR_HI) |=> $stable(stage_q));

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_RD_LO) |=> $stable(upper_q));

endmodule

// File: rtl/mdio_page_bridge.sv
// Module: mdio_page_bridge (top)
// Bridges 16-bit management-register requests onto a 32-bit internal
// register bus through a page register. Assumes one-cycle requests and a
// zero-wait-state internal slave; answers every request on the next cycle.
module mdio_page_bridge
    import mdio_pgbr_pkg::*;
#(
    parameter int PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + 7,
    localparam int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [4:0]          req_phy,
    input  logic [4:0]          req_reg,
    input  logic [HALF_W-1:0]   req_wdata,
    output logic                resp_valid,
    output logic [HALF_W-1:0]   resp_data,
    output logic                bus_wr_en,
    output logic                bus_rd_en,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2*HALF_W-1:0] bus_wdata,
    input  logic [2*HALF_W-1:0] bus_rdata
);

    localparam int PAD_W = HALF_W - PAGE_W;

    logic [PAGE_W-1:0] page_q;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] word_addr;
    logic [HALF_W-1:0] stage_q;
    logic [HALF_W-1:0] upper_q;
    logic [HALF_W-1:0] rd_next;

    mdio_pgbr_decode #(.PAGE_W(PAGE_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .page      (page_q),
        .kind      (kind),
        .word_addr (word_addr)
    );

    mdio_pgbr_halves #(.HALF_W(HALF_W)) u_halves (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wdata     (req_wdata),
        .bus_rdata (bus_rdata),
        .stage_q   (stage_q),
        .upper_q   (upper_q)
    );

    // Page register load from the dedicated location
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (kind == ACC_PAGE_WR)
            page_q <= req_wdata[PAGE_W-1:0];
    end

    // Internal bus strobes and data for the current request
    always_comb begin
        bus_addr  = word_addr;
        bus_wdata = {stage_q, req_wdata};
        bus_wr_en = (kind == ACC_WR_LO);
        bus_rd_en = (kind == ACC_RD_LO);
    end

    // Read data selection for the response
    always_comb begin
        unique case (kind)
            ACC_PAGE_RD: rd_next = {{PAD_W{1'b0}}, page_q};
            ACC_RD_LO:   rd_next = bus_rdata[HALF_W-1:0];
            ACC_RD_HI:   rd_next = upper_q;
            default:     rd_next = '1;
        endcase
    end

    // Registered response, one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid && !req_write)
                resp_data <= rd_next;
        end
    end

    // R9
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R8
    ign_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_phy[4]) |-> (!bus_wr_en && !bus_rd_en));

    // R8
    ign_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_phy[4]) |=> (resp_data == 16'hFFFF));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_phy == 5'h1F && req_reg == 5'h10)
        |=> $stable(page_q));

    // R5
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en || bus_rd_en) |-> (req_valid && req_phy[4:3] == 2'b10));

endmodule

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        resp_valid;
    logic [15:0] resp_data;
    logic        bus_wr_en;
    logic        bus_rd_en;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        s_wr, s_rd, s_rv;
    logic [15:0] s_addr, s_rdat;
    logic [31:0] s_wdata;

    always #4 clk = ~clk;

    // Bench slave: arithmetic read data from the word address
    function automatic logic [31:0] slave_word(input logic [15:0] a);
        return {a ^ 16'h5A3C, (~a) + 16'd7};
    endfunction

    assign bus_rdata = slave_word(bus_addr);

    mdio_page_bridge #(.PAGE_W(9)) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_phy (req_phy), .req_reg (req_reg), .req_wdata (req_wdata),
        .resp_valid (resp_valid), .resp_data (resp_data),
        .bus_wr_en (bus_wr_en), .bus_rd_en (bus_rd_en),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request: drive on falling edge, sample strobes, then the response
    task automatic xact(input logic wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        #1;
        s_wr = bus_wr_en; s_rd = bus_rd_en; s_addr = bus_addr; s_wdata = bus_wdata;
        @(posedge clk);
        #1;
        s_rv = resp_valid; s_rdat = resp_data;
        req_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0]  pages [4];
        logic [15:0] hi, lo, ea, keep_stage;
        logic [31:0] w;
        pages[0] = 9'h000; pages[1] = 9'h001; pages[2] = 9'h155; pages[3] = 9'h1FF;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(resp_valid == 1'b0, "R1 resp_valid", {31'd0, resp_valid}, 0);
        chk(resp_data == 16'h0, "R1 resp_data", {16'd0, resp_data}, 0);
        @(negedge clk); rst_n = 1'b1;
        xact(1'b0, 5'h1F, 5'h10, 16'h0);
        chk(s_rdat == 16'h0, "R1 page after reset", {16'd0, s_rdat}, 0);

        for (int p = 0; p < 4; p++) begin
            // R2: load page with junk above the page width
            xact(1'b1, 5'h1F, 5'h10, {7'h5B, pages[p]});
            chk(!s_wr && !s_rd, "R2 page write strobes", {30'd0, s_wr, s_rd}, 0);
            xact(1'b0, 5'h1F, 5'h10, 16'h0);
            chk(s_rdat == {7'd0, pages[p]}, "R2 page readback", {16'd0, s_rdat}, {23'd0, pages[p]});
            chk(!s_wr && !s_rd, "R2 page read strobes", {30'd0, s_wr, s_rd}, 0);
            for (int ph = 16; ph < 24; ph++) begin
                for (int ix = 0; ix < 16; ix++) begin
                    ea = 16'(pages[p] * 128 + (ph - 16) * 16 + ix);
                    hi = 16'(ix * 16'h0101) ^ 16'(pages[p]) ^ 16'(ph << 11);
                    lo = ~hi + 16'(ph);
                    // R4: high half staged, no write strobe
                    xact(1'b1, 5'(ph), 5'(2 * ix + 1), hi);
                    chk(!s_wr && !s_rd, "R4 high write no strobe", {30'd0, s_wr, s_rd}, 0);
                    chk(s_rv, "R9 resp_valid after write", {31'd0, s_rv}, 1);
                    // R5 / R3: low half commits the word
                    xact(1'b1, 5'(ph), 5'(2 * ix), lo);
                    chk(s_wr && !s_rd, "R5 low write strobe", {30'd0, s_wr, s_rd}, 2);
                    chk(s_addr == ea, "R3 write address", {16'd0, s_addr}, {16'd0, ea});
                    chk(s_wdata == {hi, lo}, "R5 write data", s_wdata, {hi, lo});
                    // R6 / R3: low half read fetches the word
                    w = slave_word(ea);
                    xact(1'b0, 5'(ph), 5'(2 * ix), 16'h0);
                    chk(s_rd && !s_wr, "R6 low read strobe", {30'd0, s_wr, s_rd}, 1);
                    chk(s_addr == ea, "R3 read address", {16'd0, s_addr}, {16'd0, ea});
                    chk(s_rdat == w[15:0], "R6 low read data", {16'd0, s_rdat}, {16'd0, w[15:0]});
                    chk(s_rv, "R9 resp_valid after read", {31'd0, s_rv}, 1);
                    // R7: high half from the latch
                    xact(1'b0, 5'(ph), 5'(2 * ix + 1), 16'h0);
                    chk(!s_rd && !s_wr, "R7 high read no strobe", {30'd0, s_wr, s_rd}, 0);
                    chk(s_rdat == w[31:16], "R7 high read data", {16'd0, s_rdat}, {16'd0, w[31:16]});
                end
            end
        end

        // R8: ignored PHY addresses wedged between the halves of a pair
        for (int ph = 0; ph < 32; ph++) begin
            if (ph >= 16 && ph < 24) continue;
            keep_stage = 16'(ph * 16'h0313 + 16'h1234);
            xact(1'b1, 5'h11, 5'h03, keep_stage);
            for (int rg = 0; rg < 32; rg += 5) begin
                if (ph == 31 && rg == 16) continue;
                xact(1'b1, 5'(ph), 5'(rg), 16'hDEAD);
                chk(!s_wr && !s_rd, "R8 ignored write strobes", {30'd0, s_wr, s_rd}, 0);
                xact(1'b0, 5'(ph), 5'(rg), 16'h0);
                chk(!s_wr && !s_rd, "R8 ignored read strobes", {30'd0, s_wr, s_rd}, 0);
                chk(s_rdat == 16'hFFFF, "R8 ignored read data", {16'd0, s_rdat}, 32'hFFFF);
            end
            xact(1'b1, 5'h11, 5'h02, 16'h00AA);
            chk(s_wdata == {keep_stage, 16'h00AA}, "R8 staged half kept", s_wdata, {keep_stage, 16'h00AA});
            chk(s_addr == 16'(9'h1FF * 128 + 16 + 1), "R8 page kept", {16'd0, s_addr},
                32'(9'h1FF * 128 + 17));
            // latched half survives an ignored read
            ea = 16'(9'h1FF * 128 + 16 + 1);
            w = slave_word(ea);
            xact(1'b0, 5'h11, 5'h02, 16'h0);
            xact(1'b0, 5'(ph), 5'h01, 16'h0);
            xact(1'b0, 5'h11, 5'h03, 16'h0);
            chk(s_rdat == w[31:16], "R8 latched half kept", {16'd0, s_rdat}, {16'd0, w[31:16]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule